// File: doc/BRIEF.md
# Phase-Aware Stimulation Trigger Controller

This block decides, sample by sample, whether a biphasic stimulus should be requested from a four-channel stimulator. Each feature sample brings an instantaneous oscillation phase, a phase-synchrony score (PLV) and a band energy value. A mode input picks the trigger rule. Phase-locked mode fires when the phase reaches a programmable target. Connectivity-locked mode also requires the synchrony score to exceed a threshold. Randomized mode compares the synchrony score against a pseudo-random threshold drawn from a 16-bit LFSR. An optional energy gate can further qualify any of these rules.

The fixed delay of the upstream filters is cancelled by subtracting a programmable offset from the target phase. A refractory timer caps the stimulation rate. Its hold-off is derived from the clock frequency and the maximum stimulation rate. A one-cycle trigger pulse is issued together with the stimulator channel it addresses, and a blanking output stays high for a programmable number of cycles so that the recording front end can be protected.

Top module: `stim_trigger_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `trig_out` and `blank_out` are 0 and `trig_chan` is 0.
- R2: In mode 0 (phase-locked), a sample with `sample_valid` high causes `trig_out` to be high in the following cycle exactly when d = (`target_phase` - `delay_offset` - `phase`) modulo 2^PH_W satisfies d <= `phase_window`. The comparison is unsigned.
- R3: In mode 1 (connectivity-locked), a sample fires only when the R2 phase condition holds and `plv` > `plv_thresh`.
- R4: In mode 2 (randomized), a sample fires when `plv` exceeds the upper M_W bits of a 16-bit LFSR. The LFSR shifts left, and its new bit 0 is bit15^bit13^bit12^bit10 (polynomial x^16+x^14+x^13+x^11+1). It starts at SEED (default 16'hACE1) and advances once for every cycle in which `sample_valid` is high, whatever the mode. Each sample is compared against the LFSR value from before that sample's advance.
- R5: In mode 3 no trigger is ever issued.
- R6: When `se_enable` is 1, a sample fires only if `energy` > `se_thresh`. When `se_enable` is 0, energy has no effect.
- R7: After a trigger, no further trigger is issued for REFRACT - 1 cycles, where REFRACT = CLK_HZ / MAX_RATE_HZ. With qualifying samples on every cycle, triggers are exactly REFRACT cycles apart.
- R8: `trig_chan` takes the value of `chan_sel` in the same cycle that `trig_out` is high. It holds that value until the next trigger.
- R9: `blank_out` is high for exactly `blank_cycles` consecutive cycles, starting with the trigger cycle. It stays low when `blank_cycles` is 0.
- R10: `trig_out` is high only in the cycle after a cycle with `sample_valid` high. It is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Feature sample strobe |
| phase | input | PH_W | Instantaneous phase, full circle = 2^PH_W |
| plv | input | M_W | Phase-synchrony score |
| energy | input | M_W | Band energy |
| mode | input | 2 | 0 phase, 1 connectivity, 2 randomized, 3 off |
| target_phase | input | PH_W | Desired stimulation phase |
| delay_offset | input | PH_W | Filter group delay expressed in phase units |
| phase_window | input | PH_W | Accepted phase lead before target |
| plv_thresh | input | M_W | Synchrony threshold for mode 1 |
| se_enable | input | 1 | Enables the energy gate |
| se_thresh | input | M_W | Energy threshold |
| chan_sel | input | CH_W | Stimulator channel to address |
| blank_cycles | input | BLK_W | Blanking length in cycles |
| trig_out | output | 1 | One-cycle stimulus request |
| trig_chan | output | CH_W | Channel of the latest request |
| blank_out | output | 1 | Front-end blanking |

## Verification
The bench builds the block with PH_W=6, M_W=4, CLK_HZ=64 and MAX_RATE_HZ=4, so REFRACT is 16 cycles. With these values every phase on the 64-step circle can be swept for several target, offset and window settings, including windows that wrap through zero. The 4-bit synchrony and energy values are swept across their whole range against thresholds and the LFSR threshold. The short refractory period makes the exact trigger spacing under continuous qualifying input cheap to measure.

// File: rtl/stim_trig_pkg.sv
package stim_trig_pkg;
   typedef enum logic [1:0] {
      TRIG_PHASE = 2'd0,
      TRIG_CONN  = 2'd1,
      TRIG_RAND  = 2'd2,
      TRIG_OFF   = 2'd3
   } trig_mode_e;

   localparam int unsigned PRBS_W = 16;
endpackage

// File: rtl/trig_phase_match.sv
module trig_phase_match #(
   parameter int unsigned PH_W = 10
) (
   input  logic [PH_W-1:0] target_phase,
   input  logic [PH_W-1:0] delay_offset,
   input  logic [PH_W-1:0] phase,
   input  logic [PH_W-1:0] phase_window,
   output logic            hit
);
   logic [PH_W-1:0] eff_target;
   logic [PH_W-1:0] lead;

   always_comb begin
      eff_target = target_phase - delay_offset;
      lead       = eff_target - phase;
      hit        = (lead <= phase_window);
   end
endmodule

// File: rtl/trig_prbs16.sv
module trig_prbs16
   import stim_trig_pkg::*;
#(
   parameter int unsigned   M_W  = 10,
   parameter logic [15:0]   SEED = 16'hACE1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step,
   output logic [M_W-1:0] thresh
);
   logic [PRBS_W-1:0] state;
   logic              fb;

   assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[14:0], fb};
   end

   generate
      if (M_W == PRBS_W) begin : g_full
         assign thresh = state;
      end else begin : g_slice
         assign thresh = state[PRBS_W-1 -: M_W];
      end
   endgenerate
endmodule

// File: rtl/trig_hold_timer.sv
module trig_hold_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/stim_trigger_ctrl.sv
module stim_trigger_ctrl
   import stim_trig_pkg::*;
#(
   parameter int unsigned PH_W        = 10,
   parameter int unsigned M_W         = 10,
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned BLK_W       = 8,
   parameter int unsigned CLK_HZ      = 32768,
   parameter int unsigned MAX_RATE_HZ = 6,
   parameter logic [15:0] SEED        = 16'hACE1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sample_valid,
   input  logic [PH_W-1:0]             phase,
   input  logic [M_W-1:0]              plv,
   input  logic [M_W-1:0]              energy,
   input  logic [1:0]                  mode,
   input  logic [PH_W-1:0]             target_phase,
   input  logic [PH_W-1:0]             delay_offset,
   input  logic [PH_W-1:0]             phase_window,
   input  logic [M_W-1:0]              plv_thresh,
   input  logic                        se_enable,
   input  logic [M_W-1:0]              se_thresh,
   input  logic [$clog2(NUM_CH)-1:0]   chan_sel,
   input  logic [BLK_W-1:0]            blank_cycles,
   output logic                        trig_out,
   output logic [$clog2(NUM_CH)-1:0]   trig_chan,
   output logic                        blank_out
);
   localparam int unsigned CH_W    = $clog2(NUM_CH);
   localparam int unsigned REFRACT = CLK_HZ / MAX_RATE_HZ;
   localparam int unsigned RC_W    = $clog2(REFRACT);
   localparam logic [RC_W-1:0] HOLD_LOAD = RC_W'(REFRACT - 1);

   generate
      if (PH_W < 2)            begin : g_bad_ph  $error("PH_W must be at least 2"); end
      if (M_W < 1 || M_W > 16) begin : g_bad_m   $error("M_W must be 1..16"); end
      if (NUM_CH < 2)          begin : g_bad_ch  $error("NUM_CH must be at least 2"); end
      if (MAX_RATE_HZ == 0 || REFRACT < 2) begin : g_bad_rate
         $error("CLK_HZ / MAX_RATE_HZ must be at least 2");
      end
      if (BLK_W < 1)           begin : g_bad_blk $error("BLK_W must be at least 1"); end
   endgenerate

   trig_mode_e  mode_q;
   logic        phase_hit;
   logic [M_W-1:0] rand_thr;
   logic        refr_busy;
   logic        rule_ok;
   logic        energy_ok;
   logic        fire;

   assign mode_q = trig_mode_e'(mode);

   trig_phase_match #(.PH_W(PH_W)) u_phase (
      .target_phase (target_phase),
      .delay_offset (delay_offset),
      .phase        (phase),
      .phase_window (phase_window),
      .hit          (phase_hit)
   );

   trig_prbs16 #(.M_W(M_W), .SEED(SEED)) u_prbs (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (sample_valid),
      .thresh (rand_thr)
   );

   always_comb begin
      unique case (mode_q)
         TRIG_PHASE: rule_ok = phase_hit;
         TRIG_CONN:  rule_ok = phase_hit && (plv > plv_thresh);
         TRIG_RAND:  rule_ok = (plv > rand_thr);
         default:    rule_ok = 1'b0;
      endcase
      energy_ok = !se_enable || (energy > se_thresh);
      fire      = sample_valid && rule_ok && energy_ok && !refr_busy;
   end

   trig_hold_timer #(.W(RC_W)) u_refract (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire),
      .load_val (HOLD_LOAD),
      .busy     (refr_busy)
   );

   trig_hold_timer #(.W(BLK_W)) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire),
      .load_val (blank_cycles),
      .busy     (blank_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_out  <= 1'b0;
         trig_chan <= '0;
      end else begin
         trig_out <= fire;
         if (fire) trig_chan <= chan_sel;
      end
   end
endmodule

// File: rtl/stim_trig_checker.sv
module stim_trig_checker #(
   parameter int unsigned REFRACT = 16,
   parameter int unsigned CH_W    = 2,
   parameter int unsigned BLK_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_valid,
   input logic [1:0]       mode,
   input logic [BLK_W-1:0] blank_cycles,
   input logic             trig_out,
   input logic [CH_W-1:0]  trig_chan,
   input logic             blank_out
);
   int unsigned since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since <= REFRACT;
      else if (trig_out)         since <= 1;
      else if (since < REFRACT)  since <= since + 1;
   end

   // R1: reset clears the outputs
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!trig_out && !blank_out && trig_chan == '0));

   // R10: a trigger only follows a sample and lasts one cycle
   a_r10_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> $past(sample_valid));
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   // R5: off mode never fires
   a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> ($past(mode) != 2'd3));

   // R7: minimum spacing between triggers
   a_r7_refractory: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (since >= REFRACT));

   // R8: channel only changes with a trigger
   a_r8_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_out |-> $stable(trig_chan));

   // R9: blanking starts with the trigger when a length is given
   a_r9_blank_start: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (blank_out == ($past(blank_cycles) != '0)));
endmodule

bind stim_trigger_ctrl stim_trig_checker #(
   .REFRACT (REFRACT),
   .CH_W    (CH_W),
   .BLK_W   (BLK_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_valid (sample_valid),
   .mode         (mode),
   .blank_cycles (blank_cycles),
   .trig_out     (trig_out),
   .trig_chan    (trig_chan),
   .blank_out    (blank_out)
);

// File: tb/stim_trigger_ctrl_test.sv
module stim_trigger_ctrl_test;
   localparam int PERIOD  = 10;
   localparam int PH_W    = 6;
   localparam int M_W     = 4;
   localparam int BLK_W   = 8;
   localparam int REFRACT = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sample_valid = 1'b0;
   logic [PH_W-1:0] phase = '0;
   logic [M_W-1:0]  plv = '0;
   logic [M_W-1:0]  energy = '0;
   logic [1:0]      mode = 2'd0;
   logic [PH_W-1:0] target_phase = '0;
   logic [PH_W-1:0] delay_offset = '0;
   logic [PH_W-1:0] phase_window = '0;
   logic [M_W-1:0]  plv_thresh = '0;
   logic            se_enable = 1'b0;
   logic [M_W-1:0]  se_thresh = '0;
   logic [1:0]      chan_sel = '0;
   logic [BLK_W-1:0] blank_cycles = 8'd3;
   logic            trig_out;
   logic [1:0]      trig_chan;
   logic            blank_out;

   int checks = 0;
   int fails = 0;
   logic [15:0] lfsr_m = 16'hACE1;
   logic [1:0]  last_chan = 2'd0;
   bit          done = 0;

   always #(PERIOD/2) clk = ~clk;

   stim_trigger_ctrl #(
      .PH_W(PH_W), .M_W(M_W), .NUM_CH(4), .BLK_W(BLK_W),
      .CLK_HZ(64), .MAX_RATE_HZ(4), .SEED(16'hACE1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .phase(phase), .plv(plv), .energy(energy), .mode(mode),
      .target_phase(target_phase), .delay_offset(delay_offset),
      .phase_window(phase_window), .plv_thresh(plv_thresh),
      .se_enable(se_enable), .se_thresh(se_thresh),
      .chan_sel(chan_sel), .blank_cycles(blank_cycles),
      .trig_out(trig_out), .trig_chan(trig_chan), .blank_out(blank_out)
   );

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic bit phase_ok(input int p);
      int d;
      d = (int'(target_phase) - int'(delay_offset) - p) & ((1 << PH_W) - 1);
      return d <= int'(phase_window);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Present one sample at a falling edge and check the result one cycle later.
   task automatic one_sample(input int p, input int pv, input int en,
                             input int ch, input bit exp, input string req);
      int blanks;
      phase = PH_W'(p); plv = M_W'(pv); energy = M_W'(en); chan_sel = 2'(ch);
      sample_valid = 1'b1;
      @(posedge clk);
      lfsr_m = lfsr_next(lfsr_m);
      @(negedge clk);
      sample_valid = 1'b0;
      check(trig_out == exp, req, int'(trig_out), int'(exp));
      if (exp) last_chan = 2'(ch);
      check(trig_chan == last_chan, "R8", int'(trig_chan), int'(last_chan));
      blanks = int'(blank_out);
      for (int i = 1; i < REFRACT; i++) begin
         @(negedge clk);
         blanks += int'(blank_out);
      end
      check(blanks == (exp ? int'(blank_cycles) : 0), "R9", blanks,
            exp ? int'(blank_cycles) : 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      @(negedge clk); @(negedge clk);
      check(trig_out == 0 && blank_out == 0 && trig_chan == 0, "R1",
            int'(trig_out) + int'(blank_out) + int'(trig_chan), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(trig_out == 0 && blank_out == 0, "R1", int'(trig_out), 0);

      // R2: phase-locked, plain window
      mode = 2'd0; target_phase = 6'd32; delay_offset = 6'd5; phase_window = 6'd3;
      for (int p = 0; p < 64; p++) one_sample(p, 0, 0, p % 4, phase_ok(p), "R2");
      // R2: window wrapping through zero
      target_phase = 6'd2; delay_offset = 6'd10; phase_window = 6'd7; blank_cycles = 8'd5;
      for (int p = 0; p < 64; p++) one_sample(p, 0, 0, (p + 1) % 4, phase_ok(p), "R2");
      // R2: zero window, no blanking
      target_phase = 6'd63; delay_offset = 6'd0; phase_window = 6'd0; blank_cycles = 8'd0;
      for (int p = 0; p < 64; p++) one_sample(p, 0, 0, 3, phase_ok(p), "R2");

      // R3: connectivity-locked
      mode = 2'd1; target_phase = 6'd20; delay_offset = 6'd4; phase_window = 6'd2;
      blank_cycles = 8'd2; plv_thresh = 4'd9;
      for (int v = 0; v < 16; v++) one_sample(15, v, 0, v % 4, v > 9, "R3");
      for (int p = 0; p < 64; p++) one_sample(p, 12, 0, 1, phase_ok(p), "R3");
      for (int p = 0; p < 64; p++) one_sample(p, 9, 0, 2, 1'b0, "R3");

      // R6: energy gate across the whole energy range
      mode = 2'd0; se_enable = 1'b1; se_thresh = 4'd6;
      for (int e = 0; e < 16; e++) one_sample(15, 0, e, 0, e > 6, "R6");
      se_enable = 1'b0;
      for (int e = 0; e < 16; e++) one_sample(15, 0, e, 1, 1'b1, "R6");

      // R4: randomized threshold from the LFSR
      mode = 2'd2;
      for (int k = 0; k < 64; k++) begin
         int v;
         v = (k * 7 + 3) % 16;
         one_sample(0, v, 0, k % 4, v > int'(lfsr_m[15:12]), "R4");
      end

      // R5: off mode
      mode = 2'd3;
      for (int k = 0; k < 16; k++) one_sample(15, 15, 15, 2, 1'b0, "R5");

      // R10: qualifying inputs without a strobe
      mode = 2'd0; phase = 6'd15;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         check(trig_out == 0, "R10", int'(trig_out), 0);
      end

      // R7: continuous qualifying samples give triggers exactly REFRACT apart
      begin
         int last_t; int n; int t;
         last_t = -1; n = 0; t = 0;
         blank_cycles = 8'd3; sample_valid = 1'b1;
         while (n < 5) begin
            @(negedge clk);
            t++;
            if (trig_out) begin
               if (last_t >= 0) check(t - last_t == REFRACT, "R7", t - last_t, REFRACT);
               last_t = t; n++;
            end
         end
         sample_valid = 1'b0;
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule